// File: doc/BRIEF.md
# Single-Accumulator Microsequenced Core

This block is a minimal stored-program processor built around one accumulator register. A program counter, an instruction register and the accumulator share one synchronous memory port. A four-step control sequencer drives each instruction. It runs fetch-address, instruction capture, operand address and execute in that order, so every instruction takes exactly four clock cycles. In every step the sequencer produces raw datapath controls: register load enables, an address source select, a write enable and the ALU controls (zero the A input, invert B, carry in, logic or adder).

The address multiplexer presents the program counter during fetch. It presents the instruction's address field during the operand steps. The B multiplexer feeds the ALU either the memory read data or the zero-extended address field, which serves as a small immediate. The memory sits outside the block. It returns read data one cycle after the address is presented and writes on the clock edge where the write enable is high.

Top module: `accu_core`

## Requirements
- R1: While reset is low, acc_out and pc_out read zero and mem_we is low. In the first cycle after reset is released, mem_addr is 0.
- R2: Every instruction takes exactly four cycles. The first instruction's result appears on acc_out four rising edges after reset is released. pc_out has advanced by one two edges after its fetch began.
- R3: An instruction word holds the opcode in bits [7:4] and an address or immediate field in bits [3:0]. The codes are 1 LOAD, 2 STORE, 3 ADD, 4 SUB, 5 AND, 6 OR, 7 JMP and 8 LDI.
- R4: LOAD (1) copies the memory word at the field address into the accumulator.
- R5: STORE (2) writes the accumulator to the field address. mem_we is high for a single cycle per STORE.
- R6: ADD (3) adds the memory word to the accumulator modulo 256.
- R7: SUB (4) subtracts the memory word from the accumulator modulo 256.
- R8: AND (5) and OR (6) combine the accumulator bitwise with the memory word.
- R9: LDI (8) loads the zero-extended 4-bit field into the accumulator.
- R10: JMP (7) makes the next fetch come from the field address and leaves the accumulator unchanged.
- R11: Codes 0 and 9 to 15 change neither the accumulator nor memory.
- R12: The program counter wraps from 15 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | ADDR_W | Memory address, taken from the PC or the IR field |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | DATA_W | Memory write data (the accumulator) |
| mem_rdata | input | DATA_W | Memory read data, one cycle after the address |
| acc_out | output | DATA_W | Accumulator value |
| pc_out | output | ADDR_W | Program counter value |

## Verification
Short programs run from a bench memory. Each program is chosen so that a wrong opcode decode or a wrong ALU control gives a different accumulator or memory result. A carry-out sum separates a true modulo add from a saturating or width-extended one. A borrowing subtraction separates B inversion with carry-in from a plain add. Operands with partly overlapping bits separate AND from OR. A jump over two loads, a run of undefined codes, and a program that runs through address 15 separate correct PC sourcing from fall-through, false writes and a missing wrap.

// File: rtl/accu_pkg.sv
package accu_pkg;

  localparam int OP_W = 4;

  localparam logic [OP_W-1:0] OPC_LOAD  = 4'd1;
  localparam logic [OP_W-1:0] OPC_STORE = 4'd2;
  localparam logic [OP_W-1:0] OPC_ADD   = 4'd3;
  localparam logic [OP_W-1:0] OPC_SUB   = 4'd4;
  localparam logic [OP_W-1:0] OPC_AND   = 4'd5;
  localparam logic [OP_W-1:0] OPC_OR    = 4'd6;
  localparam logic [OP_W-1:0] OPC_JMP   = 4'd7;
  localparam logic [OP_W-1:0] OPC_LDI   = 4'd8;

  typedef enum logic [1:0] {
    PH_FETCH  = 2'd0,
    PH_IRLD   = 2'd1,
    PH_OPADDR = 2'd2,
    PH_EXEC   = 2'd3
  } phase_e;

  typedef struct packed {
    logic zero_a;
    logic b_inv;
    logic carry_in;
    logic use_logic;
    logic b_imm;
  } alu_ctrl_t;

  typedef struct packed {
    logic      pc_we;
    logic      pc_jump;
    logic      ir_we;
    logic      acc_we;
    logic      mem_we;
    logic      addr_ir;
    alu_ctrl_t alu;
  } ctrl_t;

endpackage

// File: rtl/accu_reg.sv
module accu_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (en) begin
      q <= d;
    end
  end

endmodule

// File: rtl/accu_alu.sv
module accu_alu
  import accu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_ctrl_t    ctl,
  output logic [W-1:0] y
);

  logic [W-1:0] a_eff;
  logic [W-1:0] b_eff;
  logic [W-1:0] sum;
  logic [W-1:0] bitwise;

  always_comb begin
    a_eff   = ctl.zero_a ? '0 : a;
    // In adder mode B-invert complements the operand; in logic mode it picks OR.
    b_eff   = (ctl.b_inv && !ctl.use_logic) ? ~b : b;
    sum     = a_eff + b_eff + W'(ctl.carry_in);
    bitwise = ctl.b_inv ? (a_eff | b) : (a_eff & b);
    y       = ctl.use_logic ? bitwise : sum;
  end

endmodule

// File: rtl/accu_ctrl.sv
module accu_ctrl
  import accu_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [OP_W-1:0] opcode,
  output phase_e          phase,
  output ctrl_t           ctl
);

  phase_e phase_q;
  phase_e phase_d;

  always_comb begin
    unique case (phase_q)
      PH_FETCH:  phase_d = PH_IRLD;
      PH_IRLD:   phase_d = PH_OPADDR;
      PH_OPADDR: phase_d = PH_EXEC;
      default:   phase_d = PH_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_FETCH;
    end else begin
      phase_q <= phase_d;
    end
  end

  always_comb begin
    ctl = '0;
    unique case (phase_q)
      PH_FETCH: begin
        ctl.addr_ir = 1'b0;
      end
      PH_IRLD: begin
        ctl.ir_we = 1'b1;
        ctl.pc_we = 1'b1;
      end
      PH_OPADDR: begin
        ctl.addr_ir = 1'b1;
        if (opcode == OPC_STORE) ctl.mem_we = 1'b1;
        if (opcode == OPC_JMP) begin
          ctl.pc_we   = 1'b1;
          ctl.pc_jump = 1'b1;
        end
      end
      default: begin
        ctl.addr_ir = 1'b1;
        case (opcode)
          OPC_LOAD: begin
            ctl.acc_we     = 1'b1;
            ctl.alu.zero_a = 1'b1;
          end
          OPC_ADD: ctl.acc_we = 1'b1;
          OPC_SUB: begin
            ctl.acc_we       = 1'b1;
            ctl.alu.b_inv    = 1'b1;
            ctl.alu.carry_in = 1'b1;
          end
          OPC_AND: begin
            ctl.acc_we        = 1'b1;
            ctl.alu.use_logic = 1'b1;
          end
          OPC_OR: begin
            ctl.acc_we        = 1'b1;
            ctl.alu.use_logic = 1'b1;
            ctl.alu.b_inv     = 1'b1;
          end
          OPC_LDI: begin
            ctl.acc_we     = 1'b1;
            ctl.alu.zero_a = 1'b1;
            ctl.alu.b_imm  = 1'b1;
          end
          default: ctl.acc_we = 1'b0;
        endcase
      end
    endcase
  end

  assign phase = phase_q;

  // R5: a store asserts the write strobe for exactly one cycle
  p_we_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.mem_we |=> !ctl.mem_we);

  // R2: register writes never overlap within a step
  p_one_writer_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctl.ir_we, ctl.acc_we, ctl.mem_we}));

  // R2: the step sequence advances by one every cycle
  p_phase_walk_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_EXEC) |=> (phase_q == PH_FETCH));

endmodule

// File: rtl/accu_core.sv
module accu_core
  import accu_pkg::*;
#(
  parameter int ADDR_W = 4,
  localparam int DATA_W = OP_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] acc_out,
  output logic [ADDR_W-1:0] pc_out
);

  ctrl_t             ctl;
  phase_e            phase;
  logic [ADDR_W-1:0] pc_q;
  logic [ADDR_W-1:0] pc_d;
  logic [DATA_W-1:0] ir_q;
  logic [DATA_W-1:0] acc_q;
  logic [DATA_W-1:0] alu_y;
  logic [DATA_W-1:0] b_operand;
  logic [ADDR_W-1:0] ir_field;
  logic [OP_W-1:0]   ir_op;

  assign ir_field = ir_q[ADDR_W-1:0];
  assign ir_op    = ir_q[DATA_W-1 -: OP_W];

  accu_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .opcode (ir_op),
    .phase  (phase),
    .ctl    (ctl)
  );

  always_comb begin
    pc_d      = ctl.pc_jump ? ir_field : (pc_q + ADDR_W'(1));
    mem_addr  = ctl.addr_ir ? ir_field : pc_q;
    b_operand = ctl.alu.b_imm ? {{OP_W{1'b0}}, ir_field} : mem_rdata;
  end

  accu_alu #(.W(DATA_W)) u_alu (
    .a   (acc_q),
    .b   (b_operand),
    .ctl (ctl.alu),
    .y   (alu_y)
  );

  accu_reg #(.W(ADDR_W)) u_pc (
    .clk (clk), .rst_n (rst_n), .en (ctl.pc_we), .d (pc_d), .q (pc_q)
  );

  accu_reg #(.W(DATA_W)) u_ir (
    .clk (clk), .rst_n (rst_n), .en (ctl.ir_we), .d (mem_rdata), .q (ir_q)
  );

  accu_reg #(.W(DATA_W)) u_acc (
    .clk (clk), .rst_n (rst_n), .en (ctl.acc_we), .d (alu_y), .q (acc_q)
  );

  assign mem_we    = ctl.mem_we;
  assign mem_wdata = acc_q;
  assign acc_out   = acc_q;
  assign pc_out    = pc_q;

  // R2, R12: the capture step advances the PC by one, wrapping at the top
  p_pc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.ir_we |=> (pc_q == $past(pc_q) + ADDR_W'(1)));

  // R10: a jump lands on the instruction's field
  p_jump_dest_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.pc_jump |=> (pc_q == $past(ir_field)));

  // R11: without a load enable the accumulator keeps its value
  p_acc_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.acc_we |=> $stable(acc_q));

  // R3: the instruction register only changes in the capture step
  p_ir_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IRLD) |=> $stable(ir_q));

endmodule

// File: tb/accu_core_bench.sv
module accu_core_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] mem_addr;
  logic       mem_we;
  logic [7:0] mem_wdata;
  logic [7:0] mem_rdata = 8'h00;
  logic [7:0] acc_out;
  logic [3:0] pc_out;
  logic [7:0] mem [16];
  int         checks = 0;
  int         errors = 0;
  int         we_count = 0;

  always #5 clk = ~clk;

  accu_core u_accu_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .acc_out   (acc_out),
    .pc_out    (pc_out)
  );

  always @(posedge clk) begin
    if (mem_we) begin
      mem[mem_addr] <= mem_wdata;
      we_count <= we_count + 1;
    end
    mem_rdata <= mem[mem_addr];
  end

  function automatic logic [7:0] ins(input logic [3:0] op, input logic [3:0] fld);
    return {op, fld};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hold_reset();
    rst_n = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 16; i++) mem[i] = 8'h00;
    we_count = 0;
  endtask

  task automatic release_reset();
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset_and_timing();
    hold_reset();
    mem[0] = ins(4'd1, 4'd10);
    mem[1] = ins(4'd7, 4'd1);
    mem[10] = 8'h5A;
    chk("R1 acc in reset", acc_out, 8'h00);
    chk("R1 pc in reset", {4'h0, pc_out}, 8'h00);
    chk("R1 we in reset", {7'h0, mem_we}, 8'h00);
    release_reset();
    chk("R1 first address", {4'h0, mem_addr}, 8'h00);
    step(2);
    chk("R2 pc after capture", {4'h0, pc_out}, 8'h01);
    step(1);
    chk("R2 acc not yet written", acc_out, 8'h00);
    step(1);
    chk("R2 R4 load on fourth edge", acc_out, 8'h5A);
  endtask

  task automatic t_add_store();
    hold_reset();
    mem[0] = ins(4'd1, 4'd10);
    mem[1] = ins(4'd3, 4'd11);
    mem[2] = ins(4'd2, 4'd12);
    mem[3] = ins(4'd7, 4'd3);
    mem[10] = 8'h25;
    mem[11] = 8'h13;
    release_reset();
    step(20);
    chk("R6 add result", acc_out, 8'h38);
    chk("R5 stored word", mem[12], 8'h38);
    chk("R5 single write strobe", 8'(we_count), 8'd1);
  endtask

  task automatic t_add_wrap();
    hold_reset();
    mem[0] = ins(4'd1, 4'd10);
    mem[1] = ins(4'd3, 4'd11);
    mem[2] = ins(4'd7, 4'd2);
    mem[10] = 8'hF0;
    mem[11] = 8'h25;
    release_reset();
    step(16);
    chk("R6 add modulo 256", acc_out, 8'h15);
  endtask

  task automatic t_sub();
    hold_reset();
    mem[0] = ins(4'd1, 4'd10);
    mem[1] = ins(4'd4, 4'd11);
    mem[2] = ins(4'd7, 4'd2);
    mem[10] = 8'h10;
    mem[11] = 8'h25;
    release_reset();
    step(16);
    chk("R7 sub with borrow", acc_out, 8'hEB);
  endtask

  task automatic t_logic();
    hold_reset();
    mem[0] = ins(4'd1, 4'd10);
    mem[1] = ins(4'd5, 4'd11);
    mem[2] = ins(4'd2, 4'd12);
    mem[3] = ins(4'd6, 4'd13);
    mem[4] = ins(4'd7, 4'd4);
    mem[10] = 8'hCA;
    mem[11] = 8'h6F;
    mem[13] = 8'h31;
    release_reset();
    step(24);
    chk("R8 and result stored", mem[12], 8'h4A);
    chk("R8 or result", acc_out, 8'h7B);
  endtask

  task automatic t_ldi();
    hold_reset();
    mem[0] = ins(4'd1, 4'd10);
    mem[1] = ins(4'd8, 4'd9);
    mem[2] = ins(4'd7, 4'd2);
    mem[10] = 8'hAB;
    release_reset();
    step(16);
    chk("R9 immediate zero-extended", acc_out, 8'h09);
  endtask

  task automatic t_jump();
    hold_reset();
    mem[0] = ins(4'd8, 4'd3);
    mem[1] = ins(4'd7, 4'd4);
    mem[2] = ins(4'd8, 4'd7);
    mem[3] = ins(4'd8, 4'd8);
    mem[4] = ins(4'd3, 4'd15);
    mem[5] = ins(4'd7, 4'd5);
    mem[15] = 8'h01;
    release_reset();
    step(8);
    chk("R10 acc kept across jump", acc_out, 8'h03);
    chk("R10 pc at target", {4'h0, pc_out}, 8'h04);
    step(16);
    chk("R10 skipped loads", acc_out, 8'h04);
  endtask

  task automatic t_undefined();
    hold_reset();
    mem[0] = ins(4'd8, 4'd5);
    mem[1] = 8'h9F;
    mem[2] = 8'h0E;
    mem[3] = 8'hFA;
    mem[4] = ins(4'd7, 4'd4);
    mem[10] = 8'h77;
    mem[14] = 8'h77;
    mem[15] = 8'h77;
    release_reset();
    step(24);
    chk("R11 acc unchanged", acc_out, 8'h05);
    chk("R11 no memory write", 8'(we_count), 8'd0);
    chk("R11 word 15 kept", mem[15], 8'h77);
  endtask

  task automatic t_wrap();
    hold_reset();
    mem[0] = ins(4'd7, 4'd14);
    mem[13] = 8'h10;
    mem[14] = ins(4'd8, 4'd6);
    mem[15] = ins(4'd3, 4'd13);
    release_reset();
    step(10);
    chk("R12 pc wraps to 0", {4'h0, pc_out}, 8'h00);
    step(2);
    chk("R12 instruction at 15 ran", acc_out, 8'h16);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset_and_timing();
    t_add_store();
    t_add_wrap();
    t_sub();
    t_logic();
    t_ldi();
    t_jump();
    t_undefined();
    t_wrap();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule